// File: doc/BRIEF.md
# Multi-Word Arithmetic Unit with Split Carry Chains

This unit speeds up arithmetic on numbers wider than one machine word. It has three operations. The first is a widening unsigned multiply. One factor comes from an implicit accumulator input, and the two halves of the product go to two separate destinations. The second and third are add-with-carry operations, each with its own carry flag. One add reads and writes only the carry flag (CF). The other uses the overflow flag (OF) as its carry and reads and writes only that flag. The multiply touches no flag, and each add leaves the other flag alone. Software can therefore run two long addition chains side by side and place multiplies between their steps without saving any flag.

Operations enter through a valid/ready pair. The unit returns results on a single write-back port. That port carries a destination slot bit: slot 0 is the primary destination and slot 1 is the secondary destination. Each flag has its own value output and its own write enable. A controller drives the flow with five states:

- `ST_IDLE`: no result is pending.
- `ST_ADD_OUT`: an add result is on the port.
- `ST_MUL_PROD`: the product register is loading.
- `ST_MUL_LO`: the low half is on the port.
- `ST_MUL_HI`: the high half is on the port.

The controller makes these transitions:

- An accepted add moves to `ST_ADD_OUT`.
- An accepted multiply moves to `ST_MUL_PROD`.
- The multiply always steps `ST_MUL_PROD` → `ST_MUL_LO` → `ST_MUL_HI`.
- Any ready state with no accepted operation returns to `ST_IDLE`.
- An accepted no-op also returns to `ST_IDLE`.

Top module: `mpa_unit`

## Requirements
- R1: After reset, `wb_en`, `cf_we` and `of_we` are low and `in_ready` is high.
- R2: An accepted operation with `in_op` = 2'b00 (no-op) produces no write-back and no flag write in the following cycle.
- R3: An accepted multiply (`in_op` = 2'b01) presents the low W bits of `in_acc * in_b` on `wb_data` with `wb_slot` = 1, two cycles after acceptance.
- R4: One cycle after the low half, the multiply presents the high W bits of the product with `wb_slot` = 0. The high half is therefore written last.
- R5: A multiply never raises `cf_we` or `of_we`.
- R6: `in_ready` is low in the two cycles after a multiply is accepted, and high in every other state.
- R7: A carry-chain add (`in_op` = 2'b10) presents `in_a + in_b + in_cf` on slot 0 one cycle after acceptance. In that cycle `cf_we` is 1 and `flag_cf` is the carry out of bit W-1, while `of_we` stays 0.
- R8: An overflow-chain add (`in_op` = 2'b11) presents `in_a + in_b + in_of` on slot 0 one cycle after acceptance. In that cycle `of_we` is 1 and `flag_of` is the signed overflow of that sum, while `cf_we` stays 0.
- R9: An operation offered while `in_ready` is low is ignored. No extra result follows the multiply in progress.
- R10: Two 128-bit additions run with their limbs interleaved, one through the CF chain and one through the OF chain, with each flag fed back only when its write enable is set. The CF chain yields the exact 128-bit sum, and the OF chain yields its own limb-wise reference.
- R11: `cf_we` and `of_we` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The unit accepts an operation this cycle |
| in_op | input | 2 | 00 no-op, 01 multiply, 10 CF add, 11 OF add |
| in_acc | input | W | Implicit multiply factor |
| in_a | input | W | Add destination operand |
| in_b | input | W | Source operand (multiply factor, add addend) |
| in_cf | input | 1 | Current carry flag |
| in_of | input | 1 | Current overflow flag |
| wb_en | output | 1 | Write-back valid |
| wb_slot | output | 1 | 0 primary destination, 1 secondary destination |
| wb_data | output | W | Write-back value |
| cf_we | output | 1 | Carry flag write enable |
| flag_cf | output | 1 | New carry flag |
| of_we | output | 1 | Overflow flag write enable |
| flag_of | output | 1 | New overflow flag |

## Verification
The multiply's final high-half write-back and the acceptance of the next operation share one cycle, because `ST_MUL_HI` is a ready state. The bench offers an add exactly in that cycle and checks two things: the high half is intact, and the add result follows on the next cycle. The bench also holds an add offer through the busy states of a multiply and checks that the offer has no effect. Flag independence is judged by the interleaved 128-bit chains, which would diverge from their references if either add disturbed the other's flag.

// File: rtl/mpa_pkg.sv
package mpa_pkg;

    typedef enum logic [1:0] {
        OP_NOP  = 2'b00,
        OP_MULW = 2'b01,
        OP_ADDC = 2'b10,
        OP_ADDO = 2'b11
    } mpa_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADD_OUT,
        ST_MUL_PROD,
        ST_MUL_LO,
        ST_MUL_HI
    } mpa_state_e;

    localparam logic SLOT_PRI = 1'b0;
    localparam logic SLOT_SEC = 1'b1;

endpackage

// File: rtl/mpa_adder.sv
module mpa_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W:0] full;

    assign full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    assign sum  = full[W-1:0];
    assign cout = full[W];
    // signed overflow: equal operand signs, result sign differs
    assign ovf  = (a[W-1] == b[W-1]) && (full[W-1] != a[W-1]);
endmodule

// File: rtl/mpa_mul_stage.sv
module mpa_mul_stage #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,
    output logic [2*W-1:0] prod
);
    localparam int PW = 2 * W;

    logic [PW-1:0] xw, yw;

    assign xw = PW'(x);
    assign yw = PW'(y);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            prod <= '0;
        else if (load)
            prod <= xw * yw;
    end
endmodule

// File: rtl/mpa_unit.sv
module mpa_unit
    import mpa_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [1:0]   in_op,
    input  logic [W-1:0] in_acc,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic         in_cf,
    input  logic         in_of,
    output logic         wb_en,
    output logic         wb_slot,
    output logic [W-1:0] wb_data,
    output logic         cf_we,
    output logic         flag_cf,
    output logic         of_we,
    output logic         flag_of
);
    localparam int PW = 2 * W;

    mpa_state_e    state_q, state_d;
    mpa_op_e       op_in, op_q;
    logic [W-1:0]  a_q, b_q, acc_q;
    logic          cin_q;
    logic          accept;
    logic [W-1:0]  add_sum;
    logic          add_cout, add_ovf;
    logic [PW-1:0] prod;

    assign op_in  = mpa_op_e'(in_op);
    assign accept = in_valid && in_ready;

    mpa_adder #(.W(W)) u_adder (
        .a(a_q), .b(b_q), .cin(cin_q),
        .sum(add_sum), .cout(add_cout), .ovf(add_ovf)
    );

    mpa_mul_stage #(.W(W)) u_mul (
        .clk(clk), .rst_n(rst_n),
        .load(state_q == ST_MUL_PROD),
        .x(acc_q), .y(b_q), .prod(prod)
    );

    // operand capture at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= OP_NOP;
            a_q   <= '0;
            b_q   <= '0;
            acc_q <= '0;
            cin_q <= 1'b0;
        end else if (accept) begin
            op_q  <= op_in;
            a_q   <= in_a;
            b_q   <= in_b;
            acc_q <= in_acc;
            cin_q <= (op_in == OP_ADDC) ? in_cf : in_of;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_MUL_PROD: state_d = ST_MUL_LO;
            ST_MUL_LO:   state_d = ST_MUL_HI;
            ST_IDLE, ST_ADD_OUT, ST_MUL_HI: begin
                if (accept) begin
                    unique case (op_in)
                        OP_MULW:          state_d = ST_MUL_PROD;
                        OP_ADDC, OP_ADDO: state_d = ST_ADD_OUT;
                        OP_NOP:           state_d = ST_IDLE;
                    endcase
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_ready = 1'b1;
        wb_en    = 1'b0;
        wb_slot  = SLOT_PRI;
        wb_data  = '0;
        cf_we    = 1'b0;
        flag_cf  = 1'b0;
        of_we    = 1'b0;
        flag_of  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ADD_OUT: begin
                wb_en   = 1'b1;
                wb_data = add_sum;
                if (op_q == OP_ADDC) begin
                    cf_we   = 1'b1;
                    flag_cf = add_cout;
                end else begin
                    of_we   = 1'b1;
                    flag_of = add_ovf;
                end
            end
            ST_MUL_PROD: in_ready = 1'b0;
            ST_MUL_LO: begin
                in_ready = 1'b0;
                wb_en    = 1'b1;
                wb_slot  = SLOT_SEC;
                wb_data  = prod[W-1:0];
            end
            ST_MUL_HI: begin
                wb_en   = 1'b1;
                wb_data = prod[PW-1:W];
            end
            default: in_ready = 1'b1;
        endcase
    end

    // ---------------- assertions ----------------
    a_r2_nop_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_op == 2'b00) |=> (!wb_en && !cf_we && !of_we));

    a_r3_low_half: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_op == 2'b01) |-> ##2
        (wb_en && wb_slot == SLOT_SEC && wb_data == ($past(in_acc, 2) * $past(in_b, 2))));

    a_r4_high_last: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && wb_slot == SLOT_SEC) |=> (wb_en && wb_slot == SLOT_PRI));

    a_r5_mul_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_op == 2'b01) |=> (!cf_we && !of_we) ##1
        (!cf_we && !of_we) ##1 (!cf_we && !of_we));

    a_r6_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_op == 2'b01) |=> !in_ready ##1 !in_ready ##1 in_ready);

    a_r7_cf_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_op == 2'b10) |=>
        (wb_en && wb_slot == SLOT_PRI && cf_we && !of_we &&
         wb_data == $past(in_a) + $past(in_b) + W'($past(in_cf))));

    a_r8_of_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_op == 2'b11) |=>
        (wb_en && wb_slot == SLOT_PRI && of_we && !cf_we &&
         wb_data == $past(in_a) + $past(in_b) + W'($past(in_of))));

    a_r11_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !(cf_we && of_we));

endmodule

// File: tb/test_mpa_unit.sv
module test_mpa_unit;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [1:0]   in_op = 2'b00;
    logic [W-1:0] in_acc = '0, in_a = '0, in_b = '0;
    logic         in_cf = 1'b0, in_of = 1'b0;
    logic         wb_en, wb_slot, cf_we, flag_cf, of_we, flag_of;
    logic [W-1:0] wb_data;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mpa_unit #(.W(W)) i_mpa_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_acc(in_acc), .in_a(in_a), .in_b(in_b),
        .in_cf(in_cf), .in_of(in_of), .wb_en(wb_en), .wb_slot(wb_slot),
        .wb_data(wb_data), .cf_we(cf_we), .flag_cf(flag_cf),
        .of_we(of_we), .flag_of(flag_of)
    );

    function automatic logic [63:0] ref_prod(logic [31:0] x, logic [31:0] y);
        return {32'd0, x} * {32'd0, y};
    endfunction

    function automatic logic [32:0] ref_add(logic [31:0] x, logic [31:0] y, logic c);
        return {1'b0, x} + {1'b0, y} + {32'd0, c};
    endfunction

    function automatic logic ref_ovf(logic [31:0] x, logic [31:0] y, logic c);
        logic [31:0] s;
        s = x + y + {31'd0, c};
        return (x[31] == y[31]) && (s[31] != x[31]);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic offer(input logic [1:0] op, input logic [31:0] acc, input logic [31:0] a,
                         input logic [31:0] b, input logic cf, input logic of_i);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_acc = acc; in_a = a; in_b = b;
        in_cf = cf; in_of = of_i;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic do_mul(input logic [31:0] acc, input logic [31:0] b);
        logic [63:0] p;
        p = ref_prod(acc, b);
        offer(2'b01, acc, 32'h0, b, 1'b0, 1'b0);
        chk(!in_ready && !wb_en, "R6 busy1", {62'd0, in_ready, wb_en}, 64'd0);
        @(negedge clk);
        chk(!in_ready, "R6 busy2", {63'd0, in_ready}, 64'd0);
        chk(wb_en && wb_slot && wb_data == p[31:0], "R3 low", {31'd0, wb_en, wb_slot, wb_data},
            {31'd0, 1'b1, 1'b1, p[31:0]});
        chk(!cf_we && !of_we, "R5 lo flags", {62'd0, cf_we, of_we}, 64'd0);
        @(negedge clk);
        chk(wb_en && !wb_slot && wb_data == p[63:32], "R4 high", {31'd0, wb_en, wb_slot, wb_data},
            {31'd0, 1'b1, 1'b0, p[63:32]});
        chk(!cf_we && !of_we, "R5 hi flags", {62'd0, cf_we, of_we}, 64'd0);
    endtask

    task automatic do_add(input logic ofchain, input logic [31:0] a, input logic [31:0] b,
                          input logic cf, input logic of_i, output logic [31:0] s, output logic fl);
        logic c;
        logic [32:0] r;
        c = ofchain ? of_i : cf;
        r = ref_add(a, b, c);
        offer(ofchain ? 2'b11 : 2'b10, 32'h0, a, b, cf, of_i);
        s = wb_data;
        if (!ofchain) begin
            fl = flag_cf;
            chk(wb_en && !wb_slot && cf_we && !of_we && wb_data == r[31:0] && flag_cf == r[32],
                "R7 cf add", {28'd0, wb_en, wb_slot, cf_we, of_we, flag_cf, wb_data[30:0]},
                {28'd0, 1'b1, 1'b0, 1'b1, 1'b0, r[32], r[30:0]});
        end else begin
            fl = flag_of;
            chk(wb_en && !wb_slot && of_we && !cf_we && wb_data == r[31:0] &&
                flag_of == ref_ovf(a, b, c),
                "R8 of add", {28'd0, wb_en, wb_slot, cf_we, of_we, flag_of, wb_data[30:0]},
                {28'd0, 1'b1, 1'b0, 1'b0, 1'b1, ref_ovf(a, b, c), r[30:0]});
        end
        chk(!(cf_we && of_we), "R11 one flag", {62'd0, cf_we, of_we}, 64'd0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] s;
        logic fl;
        logic [127:0] x, y, u, v, ref_cf;
        logic [31:0] res_cf [4];
        logic [31:0] res_of [4];
        logic [31:0] ref_of [4];
        logic cfs, ofs, oc;
        logic [32:0] tr;
        void'($urandom(32'd2024));

        repeat (3) @(negedge clk);
        chk(!wb_en && !cf_we && !of_we && in_ready, "R1 reset",
            {60'd0, wb_en, cf_we, of_we, in_ready}, 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!wb_en && !cf_we && !of_we && in_ready, "R1 after release",
            {60'd0, wb_en, cf_we, of_we, in_ready}, 64'd1);

        // R2 no-op
        offer(2'b00, 32'h1, 32'h2, 32'h3, 1'b1, 1'b1);
        chk(!wb_en && !cf_we && !of_we, "R2 nop", {61'd0, wb_en, cf_we, of_we}, 64'd0);

        // R3/R4/R5/R6 multiply
        do_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        do_mul(32'h0, 32'hDEAD_BEEF);
        do_mul(32'h1, 32'h8000_0000);
        for (int k = 0; k < 20; k++) do_mul($urandom, $urandom);

        // R7 carry chain corners and random
        do_add(1'b0, 32'hFFFF_FFFF, 32'h0, 1'b1, 1'b0, s, fl);
        do_add(1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b1, s, fl);
        do_add(1'b0, 32'h7FFF_FFFF, 32'h0, 1'b0, 1'b1, s, fl);
        for (int k = 0; k < 20; k++) do_add(1'b0, $urandom, $urandom, 1'($urandom), 1'($urandom), s, fl);

        // R8 overflow chain corners and random
        do_add(1'b1, 32'h7FFF_FFFF, 32'h0, 1'b1, 1'b1, s, fl);
        do_add(1'b1, 32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0, s, fl);
        do_add(1'b1, 32'hFFFF_FFFF, 32'h1, 1'b0, 1'b0, s, fl);
        for (int k = 0; k < 20; k++) do_add(1'b1, $urandom, $urandom, 1'($urandom), 1'($urandom), s, fl);

        // R9: an add offered during the busy window is ignored
        @(negedge clk);
        in_valid = 1'b1; in_op = 2'b01; in_acc = 32'h0000_0003; in_b = 32'h0000_0005;
        @(negedge clk);
        in_op = 2'b10; in_a = 32'h11; in_b = 32'h22; in_cf = 1'b1;
        chk(!in_ready, "R9 busy", {63'd0, in_ready}, 64'd0);
        @(negedge clk);
        chk(wb_en && wb_slot && wb_data == 32'd15, "R9 low intact", {31'd0, wb_en, wb_slot, wb_data},
            {31'd0, 1'b1, 1'b1, 32'd15});
        in_valid = 1'b0;
        @(negedge clk);
        chk(wb_en && !wb_slot && wb_data == 32'd0, "R9 high intact", {31'd0, wb_en, wb_slot, wb_data},
            {31'd0, 1'b1, 1'b0, 32'd0});
        @(negedge clk);
        chk(!wb_en && !cf_we, "R9 ignored", {62'd0, wb_en, cf_we}, 64'd0);

        // high-half write and next acceptance in the same cycle
        @(negedge clk);
        in_valid = 1'b1; in_op = 2'b01; in_acc = 32'h1234_5678; in_b = 32'h0001_0000;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(wb_en && !wb_slot && wb_data == 32'h0000_1234 && in_ready, "R4 high with accept",
            {30'd0, in_ready, wb_en, wb_slot, wb_data}, {30'd0, 1'b1, 1'b1, 1'b0, 32'h0000_1234});
        in_valid = 1'b1; in_op = 2'b11; in_a = 32'h7FFF_FFFF; in_b = 32'h1; in_of = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        chk(wb_en && of_we && flag_of && wb_data == 32'h8000_0000, "R8 after mul",
            {29'd0, wb_en, of_we, flag_of, wb_data}, {29'd0, 1'b1, 1'b1, 1'b1, 32'h8000_0000});

        // R10 interleaved 128-bit chains with a multiply between steps
        for (int t = 0; t < 4; t++) begin
            x = {$urandom, $urandom, $urandom, $urandom};
            y = {$urandom, $urandom, $urandom, $urandom};
            u = {$urandom, $urandom, $urandom, $urandom};
            v = {$urandom, $urandom, $urandom, $urandom};
            if (t == 0) begin x = '1; y = 128'd1; end
            ref_cf = x + y;
            oc = 1'b0;
            for (int l = 0; l < 4; l++) begin
                tr = ref_add(u[32*l +: 32], v[32*l +: 32], oc);
                ref_of[l] = tr[31:0];
                oc = ref_ovf(u[32*l +: 32], v[32*l +: 32], oc);
            end
            cfs = 1'b0; ofs = 1'b0;
            for (int l = 0; l < 4; l++) begin
                do_add(1'b0, x[32*l +: 32], y[32*l +: 32], cfs, ofs, s, fl);
                res_cf[l] = s; cfs = fl;
                do_mul($urandom, $urandom);
                do_add(1'b1, u[32*l +: 32], v[32*l +: 32], cfs, ofs, s, fl);
                res_of[l] = s; ofs = fl;
            end
            chk({res_cf[3], res_cf[2], res_cf[1], res_cf[0]} == ref_cf, "R10 cf chain",
                {res_cf[1], res_cf[0]}, ref_cf[63:0]);
            chk({res_of[3], res_of[2], res_of[1], res_of[0]} ==
                {ref_of[3], ref_of[2], ref_of[1], ref_of[0]}, "R10 of chain",
                {res_of[1], res_of[0]}, {ref_of[1], ref_of[0]});
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule